// File: doc/BRIEF.md
# Tag-Renaming Dynamic Instruction Scheduler

This block accepts decoded register-to-register arithmetic instructions one per cycle and lets them run out of program order. Each accepted instruction is assigned a tag, which is the index of the station slot it occupies. It also renames its destination register in an alias table to that tag. Source operands are resolved at acceptance. A source whose producer has finished is copied as a value. A source whose producer is still in flight is recorded as that producer's tag, and the value is picked up later by watching the shared result bus.

An entry goes to its unit as soon as both of its operands are present. There are two units. The adder handles add and subtract and takes one cycle. The multiplier is pipelined and takes `MUL_LAT` cycles. Finished results are broadcast with their tag. The architectural register is written only when the broadcast tag is still that register's newest rename. Because of this, registers can change out of program order, but the final state always equals in-order execution.

Top module: `rs_sched`

## Requirements
- R1: During and after reset, nothing is broadcast or written and dispatch is not stalled. Architectural register k starts at 3*k+1, taken modulo 2^XLEN.
- R2: `disp_tag` on an accepted dispatch differs from the tag of every instruction still in flight. Every accepted instruction is broadcast exactly once, carrying that tag.
- R3: `disp_stall` is high whenever all NRS station entries are occupied. An instruction offered while `disp_stall` is high is ignored: it produces no broadcast and no register change.
- R4: A source register with no pending producer supplies its current value. A pending source waits for its producer's tag on the bus. A source whose producer broadcasts in the same cycle as the dispatch takes the bus value at once.
- R5: Entries issue as soon as both operands are present, regardless of program order. When several entries are ready for the same unit, the oldest dispatched one goes first.
- R6: `disp_op[1]`=0 selects the adder. `disp_op[0]`=1 selects subtract (rs1-rs2) and 0 selects add. Results are taken modulo 2^XLEN. An adder instruction whose sources are available is broadcast 2 cycles after its dispatch cycle, unless a multiplier result takes the bus.
- R7: `disp_op[1]`=1 selects multiply, and the result is the low XLEN bits of rs1*rs2. With sources available, it is broadcast 1+MUL_LAT cycles after its dispatch cycle.
- R8: When a multiplier result and an adder result are both due in one cycle, the multiplier result is broadcast. The adder result follows in the next cycle.
- R9: `rf_we` is asserted only in a broadcast cycle, with `rf_waddr` set to the destination and `rf_wdata` set to the broadcast value. It is asserted only if that register's newest rename is the broadcast tag.
- R10: Once every accepted instruction has been broadcast, the architectural registers hold the values that in-order execution of the accepted instructions gives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid | input | 1 | Instruction offered this cycle |
| disp_op | input | 2 | Operation: bit 1 multiply, bit 0 subtract |
| disp_rd | input | $clog2(NREG) | Destination register |
| disp_rs1 | input | $clog2(NREG) | First source register |
| disp_rs2 | input | $clog2(NREG) | Second source register |
| disp_stall | output | 1 | No free entry; offered instruction is not taken |
| disp_tag | output | $clog2(NRS) | Tag given to an instruction accepted this cycle |
| cdb_valid | output | 1 | Result broadcast this cycle |
| cdb_tag | output | $clog2(NRS) | Tag of the broadcast result |
| cdb_value | output | XLEN | Broadcast result value |
| rf_we | output | 1 | Architectural register write |
| rf_waddr | output | $clog2(NREG) | Register written |
| rf_wdata | output | XLEN | Value written |

## Verification
Counted from its dispatch cycle, an add or subtract with available sources is broadcast 2 cycles later. A multiply is broadcast 1+MUL_LAT cycles later. An add that collides with a multiplier result slips one more cycle. A consumer of a broadcast value issues from the cycle after that broadcast. The bench records the cycle number of each accepted dispatch. It samples bus and write outputs mid-cycle on every clock and compares the arrival cycle of each directed instruction with these figures. The register-write decision is checked in the broadcast cycle itself, and final register contents are compared after the machine has drained.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Arithmetic helpers kept wide; callers truncate to their data width.
  function automatic logic [63:0] fu_addsub(logic [63:0] a, logic [63:0] b, logic sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic [63:0] fu_mul(logic [63:0] a, logic [63:0] b);
    return a * b;
  endfunction

  // Architectural register value after reset.
  function automatic logic [63:0] reg_init(int k);
    return 64'(3 * k + 1);
  endfunction

endpackage

// File: rtl/rs_rat.sv
module rs_rat #(
  parameter int NREG = 8,
  parameter int XLEN = 16,
  parameter int TAGW = 2,
  parameter int RW   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0][RW-1:0]        src_addr,
  output logic [1:0]                src_rdy,
  output logic [1:0][XLEN-1:0]      src_val,
  output logic [1:0][TAGW-1:0]      src_tag,
  input  logic                      ren_we,
  input  logic [RW-1:0]             ren_rd,
  input  logic [TAGW-1:0]           ren_tag,
  input  logic                      cdb_valid,
  input  logic [TAGW-1:0]           cdb_tag,
  input  logic [RW-1:0]             cdb_rd,
  input  logic [XLEN-1:0]           cdb_val,
  output logic                      rf_we,
  output logic [RW-1:0]             rf_waddr,
  output logic [XLEN-1:0]           rf_wdata
);
  import rs_pkg::*;

  logic [NREG-1:0]           busy;
  logic [NREG-1:0][TAGW-1:0] alias_tag;
  logic [NREG-1:0][XLEN-1:0] arch;

  // Source lookup with same-cycle bus bypass.
  for (genvar s = 0; s < 2; s++) begin : g_src
    always_comb begin
      src_tag[s] = alias_tag[src_addr[s]];
      if (!busy[src_addr[s]]) begin
        src_rdy[s] = 1'b1;
        src_val[s] = arch[src_addr[s]];
      end else if (cdb_valid && cdb_tag == alias_tag[src_addr[s]]) begin
        src_rdy[s] = 1'b1;
        src_val[s] = cdb_val;
      end else begin
        src_rdy[s] = 1'b0;
        src_val[s] = '0;
      end
    end
  end

  // Only the newest rename may retire into the register.
  wire tag_current = busy[cdb_rd] && (alias_tag[cdb_rd] == cdb_tag);
  assign rf_we    = cdb_valid && tag_current;
  assign rf_waddr = cdb_rd;
  assign rf_wdata = cdb_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= '0;
      alias_tag <= '0;
      for (int k = 0; k < NREG; k++) arch[k] <= XLEN'(reg_init(k));
    end else begin
      if (rf_we) begin
        arch[cdb_rd] <= cdb_val;
        busy[cdb_rd] <= 1'b0;
      end
      if (ren_we) begin
        busy[ren_rd]      <= 1'b1;
        alias_tag[ren_rd] <= ren_tag;
      end
    end
  end

  // R9: a retiring write frees the register unless it is renamed again at once.
  a_r9_clear_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !(ren_we && ren_rd == rf_waddr)) |=> !busy[$past(rf_waddr)]);

  // R9: a dispatch rename survives a concurrent stale result.
  a_r9_rename_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ren_we |=> (busy[$past(ren_rd)] && alias_tag[$past(ren_rd)] == $past(ren_tag)));

endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int NRS  = 4,
  parameter int XLEN = 16,
  parameter int TAGW = 2,
  parameter int RW   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_we,
  input  logic [1:0]           disp_op,
  input  logic [RW-1:0]        disp_rd,
  input  logic [1:0]           s_rdy,
  input  logic [1:0][XLEN-1:0] s_val,
  input  logic [1:0][TAGW-1:0] s_tag,
  output logic                 full,
  output logic [TAGW-1:0]      free_idx,
  input  logic                 cdb_valid,
  input  logic [TAGW-1:0]      cdb_tag,
  input  logic [XLEN-1:0]      cdb_val,
  input  logic                 add_ok,
  output logic                 add_go,
  output logic [TAGW-1:0]      add_tag,
  output logic [XLEN-1:0]      add_a,
  output logic [XLEN-1:0]      add_b,
  output logic                 add_sub,
  output logic [RW-1:0]        add_rd,
  output logic                 mul_go,
  output logic [TAGW-1:0]      mul_tag,
  output logic [XLEN-1:0]      mul_a,
  output logic [XLEN-1:0]      mul_b,
  output logic [RW-1:0]        mul_rd
);

  logic [NRS-1:0]            vld, iss, is_mul, is_sub, r1, r2;
  logic [NRS-1:0][RW-1:0]    ent_rd;
  logic [NRS-1:0][XLEN-1:0]  v1, v2;
  logic [NRS-1:0][TAGW-1:0]  t1, t2;
  logic [NRS-1:0][NRS-1:0]   older;   // older[i][j]: entry i dispatched before entry j

  logic [NRS-1:0] want_add, want_mul, add_grant, mul_grant, disp_hit;
  logic [NRS-1:0] cap1, cap2;

  function automatic logic [NRS-1:0] pick_oldest(logic [NRS-1:0] req,
                                                 logic [NRS-1:0][NRS-1:0] age);
    logic [NRS-1:0] g;
    for (int i = 0; i < NRS; i++) begin
      g[i] = req[i];
      for (int j = 0; j < NRS; j++)
        if (req[j] && age[j][i]) g[i] = 1'b0;
    end
    return g;
  endfunction

  function automatic logic [TAGW-1:0] enc(logic [NRS-1:0] oh);
    logic [TAGW-1:0] r;
    r = '0;
    for (int i = 0; i < NRS; i++) if (oh[i]) r = TAGW'(i);
    return r;
  endfunction

  always_comb begin
    free_idx = '0;
    for (int i = NRS - 1; i >= 0; i--) if (!vld[i]) free_idx = TAGW'(i);
  end
  assign full = &vld;

  for (genvar i = 0; i < NRS; i++) begin : g_ent
    wire ready_i  = vld[i] && !iss[i] && r1[i] && r2[i];
    assign want_add[i] = ready_i && !is_mul[i];
    assign want_mul[i] = ready_i &&  is_mul[i];
    assign disp_hit[i] = disp_we && (free_idx == TAGW'(i));
    assign cap1[i] = vld[i] && !r1[i] && cdb_valid && (t1[i] == cdb_tag);
    assign cap2[i] = vld[i] && !r2[i] && cdb_valid && (t2[i] == cdb_tag);

    // R4: once a tag is broadcast, no live entry keeps waiting on it.
    a_r4_no_stale_wait: assert property (@(posedge clk) disable iff (!rst_n)
      cdb_valid |=> !(vld[i] && ((!r1[i] && t1[i] == $past(cdb_tag)) ||
                                 (!r2[i] && t2[i] == $past(cdb_tag)))));
  end

  assign add_grant = add_ok ? pick_oldest(want_add, older) : '0;
  assign mul_grant = pick_oldest(want_mul, older);

  assign add_go  = |add_grant;
  assign add_tag = enc(add_grant);
  assign add_a   = v1[add_tag];
  assign add_b   = v2[add_tag];
  assign add_sub = is_sub[add_tag];
  assign add_rd  = ent_rd[add_tag];

  assign mul_go  = |mul_grant;
  assign mul_tag = enc(mul_grant);
  assign mul_a   = v1[mul_tag];
  assign mul_b   = v2[mul_tag];
  assign mul_rd  = ent_rd[mul_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0; iss <= '0; is_mul <= '0; is_sub <= '0; r1 <= '0; r2 <= '0;
      ent_rd <= '0; v1 <= '0; v2 <= '0; t1 <= '0; t2 <= '0; older <= '0;
    end else begin
      for (int i = 0; i < NRS; i++) begin
        if (disp_hit[i]) begin
          vld[i]    <= 1'b1;
          iss[i]    <= 1'b0;
          is_mul[i] <= disp_op[1];
          is_sub[i] <= disp_op[0];
          ent_rd[i] <= disp_rd;
          r1[i] <= s_rdy[0]; v1[i] <= s_val[0]; t1[i] <= s_tag[0];
          r2[i] <= s_rdy[1]; v2[i] <= s_val[1]; t2[i] <= s_tag[1];
          older[i]  <= '0;
        end else begin
          if (cdb_valid && cdb_tag == TAGW'(i)) vld[i] <= 1'b0;
          if (add_grant[i] || mul_grant[i]) iss[i] <= 1'b1;
          if (cap1[i]) begin r1[i] <= 1'b1; v1[i] <= cdb_val; end
          if (cap2[i]) begin r2[i] <= 1'b1; v2[i] <= cdb_val; end
          if (disp_we) older[i][free_idx] <= vld[i];
        end
      end
    end
  end

  // R2: a broadcast always belongs to a live, issued entry.
  a_r2_retire_live: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_valid |-> (vld[cdb_tag] && iss[cdb_tag]));

  // R5: at most one entry per unit per cycle.
  a_r5_one_add: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(add_grant));
  a_r5_one_mul: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mul_grant));

  // R3: a dispatch never lands on an occupied entry.
  a_r3_slot_empty: assert property (@(posedge clk) disable iff (!rst_n)
    disp_we |=> (older[$past(free_idx)] == '0));

endmodule

// File: rtl/rs_mul.sv
module rs_mul #(
  parameter int XLEN = 16,
  parameter int TAGW = 2,
  parameter int RW   = 3,
  parameter int LAT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_v,
  input  logic [TAGW-1:0] in_tag,
  input  logic [RW-1:0]   in_rd,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_v,
  output logic [TAGW-1:0] out_tag,
  output logic [RW-1:0]   out_rd,
  output logic [XLEN-1:0] out_res
);
  import rs_pkg::*;

  logic [LAT-1:0]            sv;
  logic [LAT-1:0][TAGW-1:0]  stag;
  logic [LAT-1:0][RW-1:0]    srd;
  logic [LAT-1:0][XLEN-1:0]  sres;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0; stag <= '0; srd <= '0; sres <= '0;
    end else begin
      sv[0]   <= in_v;
      stag[0] <= in_tag;
      srd[0]  <= in_rd;
      sres[0] <= XLEN'(fu_mul(64'(in_a), 64'(in_b)));
      for (int k = 1; k < LAT; k++) begin
        sv[k] <= sv[k-1]; stag[k] <= stag[k-1];
        srd[k] <= srd[k-1]; sres[k] <= sres[k-1];
      end
    end
  end

  assign out_v   = sv[LAT-1];
  assign out_tag = stag[LAT-1];
  assign out_rd  = srd[LAT-1];
  assign out_res = sres[LAT-1];

  // R7: the pipeline front takes exactly what was issued.
  a_r7_stage_entry: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |=> (sv[0] && stag[0] == $past(in_tag)));

endmodule

// File: rtl/rs_sched.sv
module rs_sched #(
  parameter int XLEN    = 16,
  parameter int NREG    = 8,
  parameter int NRS     = 4,
  parameter int MUL_LAT = 3,
  localparam int RW     = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int TAGW   = (NRS > 1) ? $clog2(NRS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            disp_valid,
  input  logic [1:0]      disp_op,
  input  logic [RW-1:0]   disp_rd,
  input  logic [RW-1:0]   disp_rs1,
  input  logic [RW-1:0]   disp_rs2,
  output logic            disp_stall,
  output logic [TAGW-1:0] disp_tag,
  output logic            cdb_valid,
  output logic [TAGW-1:0] cdb_tag,
  output logic [XLEN-1:0] cdb_value,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata
);
  import rs_pkg::*;

  logic                 st_full;
  logic [TAGW-1:0]      st_free;
  logic [1:0]           s_rdy;
  logic [1:0][XLEN-1:0] s_val;
  logic [1:0][TAGW-1:0] s_tag;
  logic [RW-1:0]        cdb_rd;

  logic            add_ok, add_go, add_sub;
  logic [TAGW-1:0] add_tag_i;
  logic [XLEN-1:0] add_a, add_b;
  logic [RW-1:0]   add_rd_i;

  logic            mul_go;
  logic [TAGW-1:0] mul_tag_i, mul_tag_o;
  logic [XLEN-1:0] mul_a, mul_b, mul_res;
  logic [RW-1:0]   mul_rd_i, mul_rd_o;
  logic            mul_done;

  logic            add_v;
  logic [TAGW-1:0] add_tag_q;
  logic [RW-1:0]   add_rd_q;
  logic [XLEN-1:0] add_res_q;

  wire disp_fire = disp_valid && !st_full;
  assign disp_stall = st_full;
  assign disp_tag   = st_free;

  rs_rat #(.NREG(NREG), .XLEN(XLEN), .TAGW(TAGW), .RW(RW)) u_rat (
    .clk(clk), .rst_n(rst_n),
    .src_addr({disp_rs2, disp_rs1}), .src_rdy(s_rdy), .src_val(s_val), .src_tag(s_tag),
    .ren_we(disp_fire), .ren_rd(disp_rd), .ren_tag(st_free),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_rd(cdb_rd), .cdb_val(cdb_value),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
  );

  rs_station #(.NRS(NRS), .XLEN(XLEN), .TAGW(TAGW), .RW(RW)) u_st (
    .clk(clk), .rst_n(rst_n),
    .disp_we(disp_fire), .disp_op(disp_op), .disp_rd(disp_rd),
    .s_rdy(s_rdy), .s_val(s_val), .s_tag(s_tag),
    .full(st_full), .free_idx(st_free),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_value),
    .add_ok(add_ok), .add_go(add_go), .add_tag(add_tag_i), .add_a(add_a), .add_b(add_b),
    .add_sub(add_sub), .add_rd(add_rd_i),
    .mul_go(mul_go), .mul_tag(mul_tag_i), .mul_a(mul_a), .mul_b(mul_b), .mul_rd(mul_rd_i)
  );

  rs_mul #(.XLEN(XLEN), .TAGW(TAGW), .RW(RW), .LAT(MUL_LAT)) u_mul (
    .clk(clk), .rst_n(rst_n),
    .in_v(mul_go), .in_tag(mul_tag_i), .in_rd(mul_rd_i), .in_a(mul_a), .in_b(mul_b),
    .out_v(mul_done), .out_tag(mul_tag_o), .out_rd(mul_rd_o), .out_res(mul_res)
  );

  // Single-cycle adder; its output register holds while the multiplier owns the bus.
  assign add_ok = !add_v || !mul_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      add_v <= 1'b0; add_tag_q <= '0; add_rd_q <= '0; add_res_q <= '0;
    end else if (add_go) begin
      add_v     <= 1'b1;
      add_tag_q <= add_tag_i;
      add_rd_q  <= add_rd_i;
      add_res_q <= XLEN'(fu_addsub(64'(add_a), 64'(add_b), add_sub));
    end else if (!mul_done) begin
      add_v <= 1'b0;
    end
  end

  // Result bus: multiplier has priority.
  assign cdb_valid = mul_done || add_v;
  assign cdb_tag   = mul_done ? mul_tag_o : add_tag_q;
  assign cdb_rd    = mul_done ? mul_rd_o  : add_rd_q;
  assign cdb_value = mul_done ? mul_res   : add_res_q;

  // R8: a blocked adder result is held unchanged for the next cycle.
  a_r8_add_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (add_v && mul_done) |=> (add_v && $stable(add_tag_q) && $stable(add_res_q)));

  // R3: no dispatch is taken while every entry is occupied.
  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_stall && !cdb_valid) |=> disp_stall);

endmodule

// File: tb/tb_rs_sched.sv
module tb_rs_sched;
  localparam int XLEN = 16, NREG = 8, NRS = 4, MUL_LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic [1:0] disp_op = '0;
  logic [2:0] disp_rd = '0, disp_rs1 = '0, disp_rs2 = '0;
  logic disp_stall, cdb_valid, rf_we;
  logic [1:0] disp_tag, cdb_tag;
  logic [XLEN-1:0] cdb_value, rf_wdata;
  logic [2:0] rf_waddr;

  rs_sched #(.XLEN(XLEN), .NREG(NREG), .NRS(NRS), .MUL_LAT(MUL_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_rd(disp_rd), .disp_rs1(disp_rs1), .disp_rs2(disp_rs2),
    .disp_stall(disp_stall), .disp_tag(disp_tag), .cdb_valid(cdb_valid),
    .cdb_tag(cdb_tag), .cdb_value(cdb_value), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata));

  always #10 clk = ~clk;   // 50 MHz

  localparam logic [1:0] ADD = 2'b00, SUB = 2'b01, MUL = 2'b10;

  int checks = 0, fails = 0, cyc = 0, n_fly = 0;
  logic [XLEN-1:0] ref_rf [NREG];   // in-order model
  logic [XLEN-1:0] mirror [NREG];   // built from observed register writes
  bit              fly [NRS];
  logic [XLEN-1:0] exp_val [NRS];
  int              exp_rd [NRS], disp_cyc [NRS], want_lat [NRS];
  string           want_req [NRS];
  bit              is_mulop [NRS];
  bit              live [NREG];
  int              last_tag [NREG];
  bit              took;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // One clock: record a dispatch taken this cycle, then check the next cycle's outputs.
  task automatic tick();
    int t, rd;
    bit wexp;
    #1;
    took = 1'b0;
    if (disp_valid && !disp_stall) begin
      t = disp_tag;
      chk(!fly[t], "R2", "tag handed out while still in flight", t, -1);
      fly[t] = 1'b1; n_fly++;
      case (disp_op)
        MUL:     exp_val[t] = ref_rf[disp_rs1] * ref_rf[disp_rs2];
        SUB:     exp_val[t] = ref_rf[disp_rs1] - ref_rf[disp_rs2];
        default: exp_val[t] = ref_rf[disp_rs1] + ref_rf[disp_rs2];
      endcase
      is_mulop[t] = disp_op[1];
      ref_rf[disp_rd] = exp_val[t];
      exp_rd[t] = disp_rd;
      disp_cyc[t] = cyc;
      live[disp_rd] = 1'b1; last_tag[disp_rd] = t;
      took = 1'b1;
    end
    @(negedge clk);
    cyc++;
    if (cdb_valid) begin
      t = cdb_tag;
      chk(fly[t], "R2", "broadcast of a tag not in flight", t, -1);
      if (fly[t]) begin
        rd = exp_rd[t];
        chk(cdb_value == exp_val[t], is_mulop[t] ? "R7" : "R6", "broadcast value",
            cdb_value, exp_val[t]);
        if (want_lat[t] >= 0)
          chk(cyc - disp_cyc[t] == want_lat[t], want_req[t], "cycles from dispatch to broadcast",
              cyc - disp_cyc[t], want_lat[t]);
        wexp = live[rd] && last_tag[rd] == t;
        chk(rf_we == wexp, "R9", "write enable for newest rename", rf_we, wexp);
        if (wexp) begin
          chk(rf_waddr == rd && rf_wdata == exp_val[t], "R9", "write address/data",
              {rf_waddr, rf_wdata}, {3'(rd), exp_val[t]});
          live[rd] = 1'b0;
        end
        fly[t] = 1'b0; n_fly--;
        want_lat[t] = -1;
      end
    end else begin
      chk(!rf_we, "R9", "write without broadcast", rf_we, 0);
    end
    if (rf_we) mirror[rf_waddr] = rf_wdata;
  endtask

  task automatic offer(logic [1:0] op, int rd, int a, int b, int lat, string req);
    disp_valid = 1'b1; disp_op = op;
    disp_rd = 3'(rd); disp_rs1 = 3'(a); disp_rs2 = 3'(b);
    #1;
    if (!disp_stall && lat >= 0) begin
      want_lat[disp_tag] = lat; want_req[disp_tag] = req;
    end
    tick();
    disp_valid = 1'b0;
  endtask

  task automatic disp(logic [1:0] op, int rd, int a, int b, int lat = -1, string req = "R6");
    do offer(op, rd, a, b, lat, req); while (!took);
  endtask

  task automatic idle(int n);
    disp_valid = 1'b0;
    repeat (n) tick();
  endtask

  task automatic drain();
    int guard = 0;
    disp_valid = 1'b0;
    while (n_fly > 0 && guard < 200) begin tick(); guard++; end
    chk(n_fly == 0, "R2", "instructions still in flight after drain", n_fly, 0);
    idle(2);
  endtask

  task automatic cmp_all(string tagline);
    for (int k = 0; k < NREG; k++)
      chk(mirror[k] == ref_rf[k], "R10", tagline, mirror[k], ref_rf[k]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired: actual=%0d expected=%0d", cyc, 20000);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) begin
      ref_rf[k] = XLEN'(3 * k + 1); mirror[k] = ref_rf[k];
      live[k] = 1'b0; last_tag[k] = -1;
    end
    for (int t = 0; t < NRS; t++) begin fly[t] = 1'b0; want_lat[t] = -1; end
    repeat (3) @(negedge clk);
    chk(!cdb_valid && !rf_we && !disp_stall, "R1", "outputs during reset",
        {cdb_valid, rf_we, disp_stall}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(!cdb_valid && !rf_we && !disp_stall, "R1", "outputs after reset",
        {cdb_valid, rf_we, disp_stall}, 0);

    // Isolated operations: latency and arithmetic (R6, R7); also proves reset values (R1).
    disp(ADD, 1, 2, 3, 2, "R6"); drain();
    disp(SUB, 2, 0, 7, 2, "R6"); drain();       // wraps below zero
    disp(MUL, 7, 7, 5, 1 + MUL_LAT, "R7"); drain();
    cmp_all("R1 reset-derived register values");

    // R5: a younger independent add overtakes an older multiply.
    disp(MUL, 3, 1, 2, 1 + MUL_LAT, "R7");
    disp(ADD, 4, 5, 6, 2, "R5");
    drain();

    // R8: add due in the same cycle as a multiply result waits one cycle.
    disp(MUL, 5, 6, 7, 1 + MUL_LAT, "R8");
    idle(1);
    disp(ADD, 0, 2, 3, 3, "R8");
    drain();

    // R5 oldest-first and R4 same-cycle bypass: the younger add lands in a lower entry.
    disp(MUL, 6, 2, 3, 1 + MUL_LAT, "R7");   // entry 0
    disp(MUL, 1, 4, 5, 1 + MUL_LAT, "R7");   // entry 1, producer
    disp(ADD, 2, 1, 7, 5, "R5");             // waits on producer
    idle(2);
    chk(disp_tag == 0, "R5", "entry 0 reused for the younger add", disp_tag, 0);
    disp(SUB, 3, 1, 0, 3, "R4");             // dispatched during producer's broadcast
    drain();

    // R3: fill every entry, then offer while stalled.
    disp(MUL, 1, 2, 3, 1 + MUL_LAT, "R7");
    disp(ADD, 4, 1, 1);
    disp(ADD, 5, 1, 4);
    disp(ADD, 6, 5, 1);
    chk(disp_stall == 1'b1, "R3", "stall with all entries occupied", disp_stall, 1);
    offer(ADD, 7, 0, 0, -1, "R3");
    chk(!took, "R3", "offer accepted while stalled", took, 0);
    drain();
    chk(mirror[7] == ref_rf[7], "R3", "register untouched by ignored offer", mirror[7], ref_rf[7]);

    // R10: five-instruction multiply/add chain with renaming hazards.
    disp(MUL, 3, 1, 2);
    disp(ADD, 4, 2, 3);
    disp(MUL, 2, 6, 7);
    disp(ADD, 5, 2, 3);
    disp(ADD, 3, 3, 5);
    drain();
    cmp_all("final register after dependency chain");

    // R9: back-to-back writes to one register; the older result must not retire.
    disp(MUL, 0, 7, 7, 1 + MUL_LAT, "R7");
    disp(ADD, 0, 1, 2, 2, "R9");
    drain();
    cmp_all("final register after write-after-write");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule